// File: doc/BRIEF.md
# Local Bus Hold Arbiter

This block decides who owns the shared external address/data and control pins: the local bus controller, or an outside master that asks for the bus. The outside master raises a hold request. The arbiter waits until no local cycle is in flight, then acknowledges. It then floats the address/data group one state later and the control group one state after that. Once the request is withdrawn, the arbiter drops the acknowledge, drives both groups again in the same state, and lets local cycles resume one state later.

The local bus controller asks for each cycle with a request line and a cycle-kind code. The arbiter answers with a start strobe and tracks the length of the cycle itself, so the wait before a grant depends on what is running: internal accesses are shortest, 16-bit external cycles are longer, and 8-bit external cycles are longest. While the outside master holds the bus, internal accesses may still start. External cycles wait, and a bus-request output tells the outside master that the local side needs the pins back.

The whole mechanism is gated by an enable input. With the enable low, the hold request is ignored and both the acknowledge and the bus-request outputs stay low.

Top module: `bus_hold_arbiter`

## Requirements
- R1: In reset and right after it, hold_ack = 0, bus_req = 0, ad_oe = 1, ctl_oe = 1.
- R2: While hold_en = 0, hold_req has no effect: hold_ack and bus_req stay 0, both output enables stay 1, and local cycles start as if no request existed.
- R3: hold_req passes through SYNC_STAGES flops (default 1). In the owned state, a sampled request blocks new local starts. hold_ack rises only on an edge where no cycle is in progress.
- R4: cyc_kind encodes 0 = internal, 1 = 16-bit external, 2 or 3 = 8-bit external. A cycle that starts occupies the bus for LEN_INT = 1, LEN_X16 = 2 or LEN_X8 = 4 states. With the hold request arriving as the cycle starts, hold_ack becomes visible LEN + 2 edges after the start edge, counting the start edge as the first.
- R5: ad_oe falls one state after hold_ack rises, and ctl_oe falls one state after that. ctl_oe is never low while ad_oe is high.
- R6: After a withdrawn request is sampled, hold_ack falls on the next edge and both enables return to 1 on that same edge. No local cycle starts in that state; one may start in the state after it.
- R7: While hold_ack = 1, bus_req registers whether an external-kind cycle is being requested. bus_req falls together with hold_ack.
- R8: While the bus is held, an internal cycle request (kind 0) is started when no cycle is in progress. External requests are not started.
- R9: Lowering hold_en while the bus is held releases it exactly as a withdrawn request does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | State clock, one period per state |
| rst | input | 1 | Synchronous active-high reset |
| hold_en | input | 1 | Enables the hold mechanism |
| hold_req | input | 1 | Outside master asks for the bus (active high) |
| cyc_req | input | 1 | Local controller asks to start a cycle |
| cyc_kind | input | 2 | Kind of the requested cycle |
| cyc_go | output | 1 | Requested cycle starts on this edge |
| hold_ack | output | 1 | Bus released to the outside master |
| bus_req | output | 1 | Local side waits for an external cycle while held |
| ad_oe | output | 1 | Drive enable of the address/data group |
| ctl_oe | output | 1 | Drive enable of the control group |

## Verification
The hardest situation to reach from the ports is a hold request that lands exactly on the edge where a local cycle of a given kind starts. Only then is the full drain latency visible. The stimulus raises hold_req and cyc_req in the same state, once for each kind, and counts edges until the acknowledge. It then walks the release through the state where no local cycle may start. A vector table also places an internal start inside the float sequence and drops the enable both while a cycle is running and while the bus is held.

// File: rtl/bha_pkg.sv
package bha_pkg;

  typedef enum logic [2:0] {
    ST_OWN  = 3'd0,
    ST_ACK  = 3'd1,
    ST_FLT  = 3'd2,
    ST_HELD = 3'd3,
    ST_BACK = 3'd4
  } arb_state_t;

  localparam logic [1:0] CK_INT = 2'd0;
  localparam logic [1:0] CK_X16 = 2'd1;
  localparam logic [1:0] CK_X8  = 2'd2;

  function automatic logic kind_is_ext(input logic [1:0] k);
    return k != CK_INT;
  endfunction

  function automatic logic state_in_hold(input arb_state_t s);
    return (s == ST_ACK) || (s == ST_FLT) || (s == ST_HELD);
  endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES:0] tap;
  assign tap[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) tap[i+1] <= 1'b0;
      else     tap[i+1] <= tap[i];
    end
  end

  assign q = tap[STAGES];

endmodule

// File: rtl/bha_tracker.sv
module bha_tracker
  import bha_pkg::*;
#(
  parameter int LEN_INT = 1,
  parameter int LEN_X16 = 2,
  parameter int LEN_X8  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] kind,
  output logic       busy
);

  localparam int LEN_A   = (LEN_INT > LEN_X16) ? LEN_INT : LEN_X16;
  localparam int LEN_MAX = (LEN_A > LEN_X8) ? LEN_A : LEN_X8;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] len_sel;

  always_comb begin
    case (kind)
      CK_INT:  len_sel = CNT_W'(LEN_INT);
      CK_X16:  len_sel = CNT_W'(LEN_X16);
      default: len_sel = CNT_W'(LEN_X8);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (start)         remain <= len_sel;
    else if (remain != '0)  remain <= remain - CNT_W'(1);
  end

  assign busy = remain != '0;

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    remain <= CNT_W'(LEN_MAX)); // R4

endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
  import bha_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_eff,
  input  logic       busy,
  input  logic       cyc_req,
  input  logic [1:0] cyc_kind,
  output logic       cyc_go,
  output logic       hold_ack,
  output logic       bus_req,
  output logic       ad_oe,
  output logic       ctl_oe
);

  arb_state_t state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_OWN:  if (req_eff && !busy) nxt = ST_ACK;
      ST_ACK:  nxt = req_eff ? ST_FLT  : ST_BACK;
      ST_FLT:  nxt = req_eff ? ST_HELD : ST_BACK;
      ST_HELD: if (!req_eff) nxt = ST_BACK;
      default: nxt = ST_OWN;
    endcase
  end

  always_comb begin
    case (state)
      ST_OWN:                 cyc_go = cyc_req && !busy && !req_eff;
      ST_ACK, ST_FLT, ST_HELD: cyc_go = cyc_req && !busy && !kind_is_ext(cyc_kind);
      default:                cyc_go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OWN;
      hold_ack <= 1'b0;
      bus_req  <= 1'b0;
      ad_oe    <= 1'b1;
      ctl_oe   <= 1'b1;
    end else begin
      state    <= nxt;
      hold_ack <= state_in_hold(nxt);
      bus_req  <= state_in_hold(nxt) && cyc_req && kind_is_ext(cyc_kind);
      ad_oe    <= !((nxt == ST_FLT) || (nxt == ST_HELD));
      ctl_oe   <= nxt != ST_HELD;
    end
  end

  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(!busy && req_eff)); // R3

  AST_FLOAT_ORDER: assert property (@(posedge clk) disable iff (rst)
    !ctl_oe |-> !ad_oe); // R5

  AST_AD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(ad_oe) |-> $past(hold_ack)); // R5

  AST_BACK_NO_GO: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold_ack) && !$past(rst)) |-> (!cyc_go && ad_oe && ctl_oe)); // R6

  AST_BREQ_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> hold_ack); // R7

  AST_NO_EXT_GO_HELD: assert property (@(posedge clk) disable iff (rst)
    (cyc_go && kind_is_ext(cyc_kind)) |-> (!hold_ack && ad_oe && ctl_oe)); // R8

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 1,
  parameter int LEN_INT     = 1,
  parameter int LEN_X16     = 2,
  parameter int LEN_X8      = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_en,
  input  logic       hold_req,
  input  logic       cyc_req,
  input  logic [1:0] cyc_kind,
  output logic       cyc_go,
  output logic       hold_ack,
  output logic       bus_req,
  output logic       ad_oe,
  output logic       ctl_oe
);

  logic req_s;
  logic req_eff;
  logic busy;

  bha_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (hold_req),
    .q   (req_s)
  );

  assign req_eff = hold_en && req_s;

  bha_tracker #(
    .LEN_INT (LEN_INT),
    .LEN_X16 (LEN_X16),
    .LEN_X8  (LEN_X8)
  ) i_tracker (
    .clk   (clk),
    .rst   (rst),
    .start (cyc_go),
    .kind  (cyc_kind),
    .busy  (busy)
  );

  bha_fsm i_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_eff  (req_eff),
    .busy     (busy),
    .cyc_req  (cyc_req),
    .cyc_kind (cyc_kind),
    .cyc_go   (cyc_go),
    .hold_ack (hold_ack),
    .bus_req  (bus_req),
    .ad_oe    (ad_oe),
    .ctl_oe   (ctl_oe)
  );

  AST_EN_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!hold_en) |-> (!hold_ack && !bus_req)); // R2

  AST_EN_OFF_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    $past(!hold_en) |-> (ad_oe && ctl_oe)); // R9

endmodule

// File: tb/test_bus_hold_arbiter.sv
module test_bus_hold_arbiter;

  logic       clk = 1'b0;
  logic       rst;
  logic       hold_en, hold_req, cyc_req;
  logic [1:0] cyc_kind;
  logic       cyc_go, hold_ack, bus_req, ad_oe, ctl_oe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bus_hold_arbiter i_bus_hold_arbiter (
    .clk      (clk),
    .rst      (rst),
    .hold_en  (hold_en),
    .hold_req (hold_req),
    .cyc_req  (cyc_req),
    .cyc_kind (cyc_kind),
    .cyc_go   (cyc_go),
    .hold_ack (hold_ack),
    .bus_req  (bus_req),
    .ad_oe    (ad_oe),
    .ctl_oe   (ctl_oe)
  );

  // stimulus: en, req, creq, kind; expected {ack, ad_oe, ctl_oe, bus_req, go}
  typedef struct packed {
    logic       en;
    logic       req;
    logic       creq;
    logic [1:0] kind;
    logic [4:0] exp;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 2'd1, 5'b01101, 4'd3}, // R3 local start
    '{1'b1, 1'b1, 1'b0, 2'd0, 5'b01100, 4'd3}, // R3 request enters sync
    '{1'b1, 1'b1, 1'b1, 2'd2, 5'b01100, 4'd3}, // R3 sampled request blocks start
    '{1'b1, 1'b1, 1'b1, 2'd2, 5'b01100, 4'd3}, // R3 waiting for drain
    '{1'b1, 1'b1, 1'b1, 2'd2, 5'b11110, 4'd7}, // R7 ack with pending external
    '{1'b1, 1'b1, 1'b1, 2'd0, 5'b10111, 4'd8}, // R8 internal start while floating
    '{1'b1, 1'b1, 1'b0, 2'd0, 5'b10000, 4'd5}, // R5 both groups floated
    '{1'b1, 1'b0, 1'b1, 2'd2, 5'b10000, 4'd8}, // R8 external not started
    '{1'b1, 1'b0, 1'b1, 2'd2, 5'b10010, 4'd7}, // R7 bus_req reports waiting
    '{1'b1, 1'b0, 1'b1, 2'd2, 5'b01100, 4'd6}, // R6 turnaround state
    '{1'b1, 1'b0, 1'b1, 2'd2, 5'b01101, 4'd6}, // R6 local start resumes
    '{1'b0, 1'b1, 1'b0, 2'd2, 5'b01100, 4'd2}, // R2 request ignored
    '{1'b0, 1'b1, 1'b0, 2'd2, 5'b01100, 4'd2}, // R2
    '{1'b0, 1'b1, 1'b1, 2'd0, 5'b01100, 4'd4}, // R4 8-bit cycle still running
    '{1'b0, 1'b1, 1'b1, 2'd0, 5'b01100, 4'd4}, // R4
    '{1'b0, 1'b1, 1'b1, 2'd0, 5'b01101, 4'd2}, // R2 start despite request
    '{1'b1, 1'b1, 1'b0, 2'd0, 5'b01100, 4'd3}, // R3 busy delays grant
    '{1'b1, 1'b1, 1'b0, 2'd0, 5'b01100, 4'd3}, // R3 grant edge
    '{1'b0, 1'b1, 1'b0, 2'd0, 5'b11100, 4'd9}, // R9 enable dropped
    '{1'b0, 1'b0, 1'b0, 2'd0, 5'b01100, 4'd9}, // R9 released
    '{1'b0, 1'b0, 1'b0, 2'd0, 5'b01100, 4'd2}  // R2
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [4:0] outs();
    return {hold_ack, ad_oe, ctl_oe, bus_req, cyc_go};
  endfunction

  task automatic idle_inputs();
    hold_en = 1'b0; hold_req = 1'b0; cyc_req = 1'b0; cyc_kind = 2'd0;
  endtask

  task automatic latency(input logic [1:0] kind, input int len);
    int n;
    @(negedge clk);
    hold_en = 1'b1; hold_req = 1'b1; cyc_req = 1'b1; cyc_kind = kind;
    #1 chk("R4 start strobe", 8'(cyc_go), 8'd1);
    @(negedge clk);
    cyc_req = 1'b0;
    n = 1;
    while (!hold_ack && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R4 drain latency", 8'(n), 8'(len + 2));
    @(negedge clk);
    chk("R5 address/data floats first", 8'({ad_oe, ctl_oe}), 8'b01);
    @(negedge clk);
    chk("R5 control floats next", 8'({ad_oe, ctl_oe}), 8'b00);
    hold_req = 1'b0; cyc_req = 1'b1; cyc_kind = 2'd2;
    @(negedge clk);
    chk("R6 ack held through sync", 8'(hold_ack), 8'd1);
    chk("R7 bus_req raised", 8'(bus_req), 8'd1);
    @(negedge clk);
    chk("R6 release and no start", 8'(outs()), 8'b01100);
    @(negedge clk);
    chk("R6 start in following state", 8'(cyc_go), 8'd1);
    cyc_req = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic enter_hold();
    @(negedge clk);
    hold_en = 1'b1; hold_req = 1'b1; cyc_req = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 held state", 8'(outs()), 8'b10000);
  endtask

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset state", 8'(outs()), 8'b01100);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      hold_en  = VECS[i].en;
      hold_req = VECS[i].req;
      cyc_req  = VECS[i].creq;
      cyc_kind = VECS[i].kind;
      #4;
      checks++;
      if (outs() !== VECS[i].exp) begin
        fails++;
        $display("FAIL R%0d vector %0d: got %b expected %b", VECS[i].rq, i, outs(), VECS[i].exp);
      end
      @(negedge clk);
    end

    idle_inputs();
    repeat (2) @(negedge clk);
    latency(2'd0, 1); // R4 internal
    latency(2'd1, 2); // R4 16-bit external
    latency(2'd2, 4); // R4 8-bit external
    idle_inputs();

    enter_hold();
    hold_en = 1'b0; // R9 enable dropped while held
    @(negedge clk);
    chk("R9 release on enable drop", 8'(outs()), 8'b01100);
    idle_inputs();
    repeat (3) @(negedge clk);

    enter_hold();
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset while held", 8'(outs()), 8'b01100);
    @(negedge clk);
    rst = 1'b0;
    idle_inputs();
    @(negedge clk);
    chk("R1 after reset", 8'(outs()), 8'b01100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule